// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block watches a 24-bit address bus and drives a bank of programmable chip-select outputs. Each select unit is configured through two 16-bit registers, a base register and an option register. A shared pin-role register gives each select a 2-bit role field. On every bus cycle, each unit compares the address against its base and block size. It also checks the cycle's direction, requested byte lanes and address space against its options. A matching unit asserts its select, timed either by the address strobe or by the data strobe.

For the same cycle the block returns a data-size acknowledge. The acknowledge comes after the number of wait states that the winning unit programs. Its width flag reports an 8-bit or a 16-bit port. CPU-space cycles are matched on interrupt priority and can request an autovector. Registers are written through a plain write-only port: a write enable, a register index and 16 bits of data.

Top module: `csdec_top`

## Requirements
- R1: After reset every register is zero, so no select asserts and no acknowledge is produced for any bus cycle.
- R2: Base register bits 15..3 hold address bits 23..11, and base bits 2..0 give the block size: 0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M. Only the address bits above the block size are compared.
- R3: Option bits 14..13 select the byte lanes: bit 14 is the upper lane and bit 13 is the lower lane. A unit matches only if at least one lane the cycle requests is enabled, so the value 00 never matches.
- R4: Option bit 11 allows reads and option bit 12 allows writes. The value 00 never matches.
- R5: For normal cycles, option bit 4 allows user accesses and option bit 5 allows supervisor accesses. A CPU-space cycle matches only a unit whose bits 5..4 are 00. Its priority field (option bits 3..1) must either be 0 or equal bus address bits 3..1. The address base is not compared for CPU-space cycles.
- R6: Option bit 10 = 0 makes a select follow the address strobe. Option bit 10 = 1 makes it assert only while the data strobe is also high.
- R7: Option bits 9..6 = w in 0..13 give w wait states. The acknowledge rises on the (w+1)-th rising clock edge after the address strobe rises, and it is held until the strobe drops. The value 14 acknowledges in the same cycle as the strobe.
- R8: The timing value 15 produces no internal acknowledge.
- R9: Each select has a 2-bit role field in the pin-role registers. Select k uses bits 2(k mod 8)+1..2(k mod 8) of index 0 (selects 0..7) or index 1 (selects 8..15). Role values 0 and 1 never assert. Role 2 acknowledges an 8-bit port (ack_wide=0) and role 3 acknowledges a 16-bit port (ack_wide=1).
- R10: When several units match, each asserts its own select. The acknowledge timing and width come from the lowest-numbered matching unit.
- R11: Option bit 15 = 1 (synchronous) delays the select by one clock relative to its strobe condition. Option bit 15 = 0 drives the select combinationally.
- R12: The autovector output is high during a CPU-space cycle matched by a unit whose option bit 0 is set.
- R13: A bus cycle that matches no unit produces no acknowledge. Register index 0 and 1 are the pin-role registers, 2+2k is the base of select k, and 3+2k is its option.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | 16 | Register write data |
| bus_as | input | 1 | Address strobe, high for the whole bus cycle |
| bus_ds | input | 1 | Data strobe |
| bus_addr | input | 24 | Bus address |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_upper | input | 1 | Upper byte lane requested |
| bus_lower | input | 1 | Lower byte lane requested |
| bus_super | input | 1 | Supervisor access |
| bus_cpu | input | 1 | CPU-space (interrupt acknowledge) cycle |
| cs | output | NUM_SEL | Chip-select outputs, active high |
| ack | output | 1 | Data-size acknowledge |
| ack_wide | output | 1 | Acknowledged port is 16 bits wide |
| avec | output | 1 | Autovector request |

## Verification
The bench programs four units with distinct sizes, lane sets, directions, spaces, strobes and wait counts. It then sends bus cycles that sit just inside and just outside each rule. Pairs of cycles that differ only in lane, direction, space or address (for example the byte past a 2K block) show which of the compare terms blocks a match. Address-strobe versus data-strobe units and asynchronous versus synchronous units are told apart by the clock in which the select first appears. Reprogramming two units to overlap, and then demoting the winner's pin role, separates the priority rule from the width and role-gating rules. Unmatched cycles are detected by a bus-error timeout in the monitor.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int ADDR_W = 24;
    localparam int BASE_LSB = 11;
    localparam int TAG_W = ADDR_W - BASE_LSB;

    typedef struct packed {
        logic       sync_mode;
        logic [1:0] lanes;
        logic [1:0] dir;
        logic       ds_strobe;
        logic [3:0] timing;
        logic [1:0] space;
        logic [2:0] ipl;
        logic       avec;
    } opt_t;

    typedef struct packed {
        logic              as_;
        logic              ds;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              upper;
        logic              lower;
        logic              sup;
        logic              cpu;
    } bus_t;

    localparam logic [3:0] TM_FAST = 4'd14;
    localparam logic [3:0] TM_EXT  = 4'd15;

    // Compare mask over address bits 23..11 for a block-size code
    function automatic logic [TAG_W-1:0] size_mask(input logic [2:0] code);
        int ign;
        case (code)
            3'd0: ign = 0;
            3'd1: ign = 2;
            3'd2: ign = 3;
            3'd3: ign = 5;
            3'd4: ign = 6;
            3'd5: ign = 7;
            3'd6: ign = 8;
            default: ign = 9;
        endcase
        size_mask = {TAG_W{1'b1}} << ign;
    endfunction

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int REG_AW  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [REG_AW-1:0]         waddr,
    input  logic [15:0]               wdata,
    output logic [1:0][15:0]          pin_q,
    output logic [NUM_SEL-1:0][15:0]  base_q,
    output opt_t [NUM_SEL-1:0]        opt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= '0;
        end else if (we) begin
            if (waddr == REG_AW'(0)) pin_q[0] <= wdata;
            if (waddr == REG_AW'(1)) pin_q[1] <= wdata;
        end
    end

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[k] <= '0;
                opt_q[k]  <= '0;
            end else if (we) begin
                if (waddr == REG_AW'(2 + 2 * k)) base_q[k] <= wdata;
                if (waddr == REG_AW'(3 + 2 * k)) opt_q[k]  <= opt_t'(wdata);
            end
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_q == '0 && base_q == '0 && opt_q == '0));

endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] base,
    input  opt_t        opt,
    input  logic [1:0]  role,
    input  bus_t        bus,
    output logic        hit,
    output logic        cs
);

    logic tag_ok, lane_ok, dir_ok, space_ok, ipl_ok, cond, cs_q;

    always_comb begin
        tag_ok  = ((bus.addr[ADDR_W-1:BASE_LSB] ^ base[15:3]) & size_mask(base[2:0])) == '0;
        lane_ok = (opt.lanes[1] & bus.upper) | (opt.lanes[0] & bus.lower);
        dir_ok  = bus.rd ? opt.dir[0] : opt.dir[1];
        ipl_ok  = (opt.ipl == 3'd0) || (opt.ipl == bus.addr[3:1]);
        if (bus.cpu) space_ok = (opt.space == 2'b00) && ipl_ok;
        else         space_ok = tag_ok && (bus.sup ? opt.space[1] : opt.space[0]);
        hit  = bus.as_ && role[1] && lane_ok && dir_ok && space_ok;
        cond = hit && (!opt.ds_strobe || bus.ds);
    end

    always_ff @(posedge clk) begin
        if (rst) cs_q <= 1'b0;
        else     cs_q <= cond;
    end

    assign cs = opt.sync_mode ? cs_q : cond;

    assert_lane_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (cs && !opt.sync_mode) |-> (opt.lanes != 2'b00 && opt.dir != 2'b00));
    assert_role_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (cs && !opt.sync_mode) |-> role[1]);
    assert_ds_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (cs && !opt.sync_mode && opt.ds_strobe) |-> (bus.ds && bus.as_));
    assert_sync_delay_R11: assert property (@(posedge clk) disable iff (rst)
        (opt.sync_mode && $rose(cs)) |-> $past(bus.as_));

endmodule

// File: rtl/csdec_ack.sv
module csdec_ack
    import csdec_pkg::*;
#(
    parameter int NUM_SEL = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_as,
    input  logic [NUM_SEL-1:0]  hit,
    input  opt_t [NUM_SEL-1:0]  opt,
    input  logic [NUM_SEL-1:0]  wide_port,
    output logic                ack,
    output logic                ack_wide
);

    localparam int IDX_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;

    logic [3:0]       cnt;
    logic [IDX_W-1:0] win;
    logic [3:0]       tm;

    always_ff @(posedge clk) begin
        if (rst || !bus_as)     cnt <= '0;
        else if (cnt != 4'hF)   cnt <= cnt + 4'd1;
    end

    always_comb begin
        win = '0;
        for (int k = NUM_SEL - 1; k >= 0; k--)
            if (hit[k]) win = IDX_W'(k);
        tm       = opt[win].timing;
        ack      = bus_as && (|hit) && (tm != TM_EXT) && (tm == TM_FAST || cnt > tm);
        ack_wide = ack && wide_port[win];
    end

    assert_ack_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        ack |-> bus_as);
    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(ack) && $past(bus_as) && bus_as && $stable(win) && $stable(hit)
         && $stable(opt)) |-> ack);
    assert_no_match_R13: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |-> !ack);

endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
#(
    parameter int NUM_SEL = 4,
    localparam int REG_AW = $clog2(2 + 2 * NUM_SEL)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [15:0]        reg_wdata,
    input  logic               bus_as,
    input  logic               bus_ds,
    input  logic [23:0]        bus_addr,
    input  logic               bus_read,
    input  logic               bus_upper,
    input  logic               bus_lower,
    input  logic               bus_super,
    input  logic               bus_cpu,
    output logic [NUM_SEL-1:0] cs,
    output logic               ack,
    output logic               ack_wide,
    output logic               avec
);

    logic [1:0][15:0]         pin_q;
    logic [NUM_SEL-1:0][15:0] base_q;
    opt_t [NUM_SEL-1:0]       opt_q;
    logic [NUM_SEL-1:0]       hit;
    logic [NUM_SEL-1:0]       wide_port;
    logic [NUM_SEL-1:0]       av_req;
    bus_t                     bus;

    assign bus = '{as_: bus_as, ds: bus_ds, addr: bus_addr, rd: bus_read,
                   upper: bus_upper, lower: bus_lower, sup: bus_super, cpu: bus_cpu};

    csdec_regs #(.NUM_SEL(NUM_SEL), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_addr), .wdata(reg_wdata),
        .pin_q(pin_q), .base_q(base_q), .opt_q(opt_q)
    );

    for (genvar k = 0; k < NUM_SEL; k++) begin : g_unit
        logic [1:0] role;
        assign role         = pin_q[k / 8][2 * (k % 8) +: 2];
        assign wide_port[k] = role[0];
        assign av_req[k]    = hit[k] && bus_cpu && opt_q[k].avec;
        csdec_match u_match (
            .clk(clk), .rst(rst), .base(base_q[k]), .opt(opt_q[k]),
            .role(role), .bus(bus), .hit(hit[k]), .cs(cs[k])
        );
    end

    assign avec = |av_req;

    csdec_ack #(.NUM_SEL(NUM_SEL)) u_ack (
        .clk(clk), .rst(rst), .bus_as(bus_as), .hit(hit), .opt(opt_q),
        .wide_port(wide_port), .ack(ack), .ack_wide(ack_wide)
    );

    assert_avec_cpu_R12: assert property (@(posedge clk) disable iff (rst)
        avec |-> (bus_cpu && bus_as));

endmodule

// File: tb/csdec_top_tb.sv
module csdec_top_tb;

    localparam int N = 4;
    localparam int AW = $clog2(2 + 2 * N);
    localparam int CYC_LEN = 18;
    localparam int BERR_LIMIT = 16;
    localparam int NONE = 99;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic bus_as = 1'b0, bus_ds = 1'b0;
    logic [23:0] bus_addr = '0;
    logic bus_read = 1'b0, bus_upper = 1'b0, bus_lower = 1'b0;
    logic bus_super = 1'b0, bus_cpu = 1'b0;
    logic [N-1:0] cs;
    logic ack, ack_wide, avec;

    int n_tests = 0;
    int n_fail = 0;

    typedef struct {
        logic [N-1:0] cs_mask;
        int           cs_first;
        int           ack_first;
        logic         wide;
        logic         av;
        string        tag;
    } item_t;

    item_t exp_q[$];

    always #5 clk = ~clk;

    csdec_top #(.NUM_SEL(N)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bus_as(bus_as), .bus_ds(bus_ds),
        .bus_addr(bus_addr), .bus_read(bus_read), .bus_upper(bus_upper),
        .bus_lower(bus_lower), .bus_super(bus_super), .bus_cpu(bus_cpu),
        .cs(cs), .ack(ack), .ack_wide(ack_wide), .avec(avec)
    );

    task automatic wr(input int idx, input logic [15:0] d);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = AW'(idx); reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    // Driver: push the expected result, then run one bus cycle
    task automatic bus_cycle(input logic [23:0] a, input logic rd, input logic up,
                             input logic lo, input logic sup, input logic cpu,
                             input logic [N-1:0] e_cs, input int e_csf,
                             input int e_ackf, input logic e_wide, input logic e_av,
                             input string tag);
        item_t it;
        it.cs_mask = e_cs; it.cs_first = e_csf; it.ack_first = e_ackf;
        it.wide = e_wide; it.av = e_av; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk); #2;
        bus_addr = a; bus_read = rd; bus_upper = up; bus_lower = lo;
        bus_super = sup; bus_cpu = cpu; bus_as = 1'b1;
        @(posedge clk); #2;
        bus_ds = 1'b1;
        repeat (CYC_LEN - 1) @(posedge clk);
        #2;
        bus_as = 1'b0; bus_ds = 1'b0;
        @(posedge clk);
    endtask

    // Monitor: observes each bus cycle and compares with the queue head
    initial begin
        bit active = 0;
        int idx = 0;
        logic [N-1:0] m_cs = '0;
        int m_csf = NONE, m_ackf = NONE;
        logic m_wide = 1'b0, m_av = 1'b0;
        item_t e;
        forever begin
            @(negedge clk);
            if (bus_as) begin
                if (!active) begin
                    active = 1; idx = 0; m_cs = '0; m_csf = NONE; m_ackf = NONE;
                    m_wide = 1'b0; m_av = 1'b0;
                end
                if (cs != '0 && m_csf == NONE) m_csf = idx;
                m_cs = m_cs | cs;
                if (avec) m_av = 1'b1;
                if (ack && m_ackf == NONE && idx < BERR_LIMIT) begin
                    m_ackf = idx; m_wide = ack_wide;
                end
                idx++;
            end else if (active) begin
                active = 0;
                n_tests++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL monitor: cycle with no expected item, actual cs=%b expected none", m_cs);
                end else begin
                    e = exp_q.pop_front();
                    if (m_cs !== e.cs_mask || m_csf != e.cs_first || m_ackf != e.ack_first
                        || m_wide !== e.wide || m_av !== e.av) begin
                        n_fail++;
                        $display("FAIL %s: actual cs=%b csf=%0d ackf=%0d wide=%b av=%b expected cs=%b csf=%0d ackf=%0d wide=%b av=%b",
                                 e.tag, m_cs, m_csf, m_ackf, m_wide, m_av,
                                 e.cs_mask, e.cs_first, e.ack_first, e.wide, e.av);
                    end
                end
            end
        end
    end

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        n_tests++;
        if (cs !== '0 || ack !== 1'b0 || avec !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual cs=%b ack=%b avec=%b expected 0 0 0", cs, ack, avec);
        end
        // R1, R13: all registers zero, nothing matches, bus-error timeout
        bus_cycle(24'h000000, 1, 1, 1, 1, 0, 4'b0000, NONE, NONE, 0, 0, "R1 reset decode");

        wr(2, 16'h1003); wr(3, 16'h78B0);   // unit0: 0x10xxxx 64K, 2 waits
        wr(4, 16'h2000); wr(5, 16'h4F90);   // unit1: 0x2000xx 2K, upper, read, DS, fast, user
        wr(6, 16'h3007); wr(7, 16'hF020);   // unit2: 0x3xxxxx 1M, sync, write, 0 waits, super
        wr(8, 16'h0000); wr(9, 16'h7BCB);   // unit3: CPU space level 5, external ack, autovector
        wr(0, 16'h00FB);                    // roles: u0=3, u1=2, u2=3, u3=3

        bus_cycle(24'h10ABCD, 1, 1, 1, 0, 0, 4'b0001, 0, 3, 1, 0, "R2 R7 64K hit two waits");
        bus_cycle(24'h11ABCD, 1, 1, 1, 0, 0, 4'b0000, NONE, NONE, 0, 0, "R2 R13 outside 64K");
        bus_cycle(24'h2007FE, 1, 1, 0, 0, 0, 4'b0010, 1, 0, 0, 0, "R3 R6 R7 upper lane DS fast");
        bus_cycle(24'h2007FE, 1, 0, 1, 0, 0, 4'b0000, NONE, NONE, 0, 0, "R3 lower lane disabled");
        bus_cycle(24'h2007FE, 0, 1, 0, 0, 0, 4'b0000, NONE, NONE, 0, 0, "R4 write to read-only");
        bus_cycle(24'h2007FE, 1, 1, 0, 1, 0, 4'b0000, NONE, NONE, 0, 0, "R5 supervisor on user-only");
        bus_cycle(24'h200800, 1, 1, 0, 0, 0, 4'b0000, NONE, NONE, 0, 0, "R2 first byte past 2K");
        bus_cycle(24'h3F0000, 0, 1, 1, 1, 0, 4'b0100, 1, 1, 1, 0, "R11 sync write 1M");
        bus_cycle(24'h3F0000, 0, 1, 1, 0, 0, 4'b0000, NONE, NONE, 0, 0, "R5 user on supervisor-only");
        bus_cycle(24'hFFFFFA, 1, 1, 1, 1, 1, 4'b1000, 0, NONE, 0, 1, "R5 R8 R12 CPU space level 5");
        bus_cycle(24'hFFFFF6, 1, 1, 1, 1, 1, 4'b0000, NONE, NONE, 0, 0, "R5 R12 CPU space level 3");

        wr(8, 16'h1003); wr(9, 16'h7970);   // unit3 overlaps unit0, 5 waits
        bus_cycle(24'h10ABCD, 1, 1, 1, 0, 0, 4'b1001, 0, 3, 1, 0, "R10 lowest unit wins");
        wr(0, 16'h00F9);                    // unit0 role 1 (alternate)
        bus_cycle(24'h10ABCD, 1, 1, 1, 0, 0, 4'b1000, 0, 6, 1, 0, "R9 role 1 gated");
        wr(0, 16'h00B9);                    // unit3 role 2 (8-bit)
        bus_cycle(24'h10ABCD, 1, 1, 1, 0, 0, 4'b1000, 0, 6, 0, 0, "R9 8-bit width");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: actual %0d items left, expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule